// File: doc/BRIEF.md
# Clock Output Divider and Source Selector

This block turns a small set of source clocks into four configurable clock outputs, one processor clock output and one buffered copy of the reference. Each configurable output picks one of three sources (reference, system synthesizer, utility synthesizer), or is parked low. It divides the chosen source by a ratio taken from a lookup indexed by a 5-bit code. The system synthesizer offers a wide, irregular set of ratios that includes odd values. The reference and utility sources offer power-of-two ratios. The processor output divides its own source by 1, 2 or 4.

All logic runs on one fast clock. Each source is presented as an edge strobe that is high for one fast-clock cycle at every edge of that source, rising and falling, so one strobe marks one source half-period. A divider by N toggles its output every N strobes. The high time and the low time are therefore both N source half-periods, for odd N as well as even N. The divider counts strobes that come from both source edges, and this has the same effect as pairing a rising-edge counter with a phase delayed by half a period. Ratio and source changes, and enable changes, are taken up only at the falling edge that closes an output period, so no shortened pulse appears. One synchronous reset clears every divider, so outputs on the same source start in phase.

Top module: `clkout_divsel`

## Requirements
- R1: While `rst` is high, every output (`clk_out`, `cpu_clk`, `ref_buf`) is low at the next clock edge and stays low.
- R2: With source code 1 (system), index k in 0..17 selects the ratio at position k of the ascending list 1, 2, 3, 4, 5, 6, 8, 10, 12, 13, 20, 24, 26, 40, 48, 52, 96, 104.
- R3: An output with ratio N and a source strobe every S fast cycles stays high for exactly N*S cycles and low for exactly N*S cycles, odd N included.
- R4: With source code 0 (reference) or 2 (utility), index 0, 1, 2, 3 selects ratio 1, 2, 4, 8.
- R5: An index outside the range of the selected source's list gives ratio 1.
- R6: `cpu_clk` divides strobe `src_edge[3]` by 1, 2, 4 for `cpu_sel` 0, 1, 2, and by 1 for `cpu_sel` 3.
- R7: `ref_buf` toggles on every reference strobe `src_edge[0]` and at no other time.
- R8: After reset, outputs with the same source and ratio toggle in the same cycle. An output whose ratio is a multiple of another's on the same source changes only in cycles where the other also changes.
- R9: A new source, ratio or enable is applied only at the falling output edge that ends a period. A high phase already in progress keeps its old length.
- R10: When an enable is low, the output stops low once its current period ends and stays low. Raising the enable again restarts the output with its configured ratio.
- R11: Source code 3 holds the output low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Fast sampling clock for all logic |
| rst | input | 1 | Synchronous active-high reset shared by all dividers |
| src_edge | input | 4 | Edge strobes: [0] reference, [1] system, [2] utility, [3] processor source |
| out_src | input | 8 | Source code per output, 2 bits each, output i at [2i+1:2i]: 0 ref, 1 sys, 2 utility, 3 parked |
| out_idx | input | 20 | Ratio index per output, 5 bits each, output i at [5i+4:5i] |
| out_en | input | 4 | Per-output enable from power management |
| cpu_sel | input | 2 | Processor clock ratio select |
| cpu_en | input | 1 | Processor clock enable |
| clk_out | output | 4 | Divided configurable clocks |
| cpu_clk | output | 1 | Divided processor clock |
| ref_buf | output | 1 | Undivided reference copy |

## Verification
A strobe counter that misses its terminal count makes one phase of the output longer or shorter than the other. That error appears on the next half-period, so every divide check compares the high time and the low time separately. A configuration register that reloads at the wrong moment gives a clipped high phase in the cycle the setting changes. A lost enable shows as an output that keeps toggling, or that never restarts, within one output period. Phase errors between dividers that share a source show within the first few periods after reset, as mismatched toggle cycles.

// File: rtl/clkdiv_pkg.sv
package clkdiv_pkg;

    localparam int RATIO_W = 7;
    localparam int IDX_W   = 5;
    localparam int SRC_W   = 2;
    localparam int N_SRC   = 3;
    localparam int EDGE_REF = 0;
    localparam int EDGE_SYS = 1;
    localparam int EDGE_UTL = 2;

    typedef enum logic [SRC_W-1:0] {
        SRC_REF = 2'd0,
        SRC_SYS = 2'd1,
        SRC_UTL = 2'd2,
        SRC_OFF = 2'd3
    } src_e;

    typedef enum logic {
        TBL_GENERAL = 1'b0,
        TBL_CPU     = 1'b1
    } table_e;

    typedef logic [RATIO_W-1:0] ratio_t;
    typedef logic [IDX_W-1:0]   idx_t;

    typedef struct packed {
        src_e   src;
        ratio_t ratio;
    } chan_cfg_t;

    function automatic ratio_t sys_ratio(input idx_t idx);
        ratio_t r;
        case (idx)
            5'd0:  r = 7'd1;
            5'd1:  r = 7'd2;
            5'd2:  r = 7'd3;
            5'd3:  r = 7'd4;
            5'd4:  r = 7'd5;
            5'd5:  r = 7'd6;
            5'd6:  r = 7'd8;
            5'd7:  r = 7'd10;
            5'd8:  r = 7'd12;
            5'd9:  r = 7'd13;
            5'd10: r = 7'd20;
            5'd11: r = 7'd24;
            5'd12: r = 7'd26;
            5'd13: r = 7'd40;
            5'd14: r = 7'd48;
            5'd15: r = 7'd52;
            5'd16: r = 7'd96;
            5'd17: r = 7'd104;
            default: r = 7'd1;
        endcase
        return r;
    endfunction

    function automatic ratio_t pow2_ratio(input idx_t idx);
        ratio_t r;
        case (idx)
            5'd0: r = 7'd1;
            5'd1: r = 7'd2;
            5'd2: r = 7'd4;
            5'd3: r = 7'd8;
            default: r = 7'd1;
        endcase
        return r;
    endfunction

    function automatic ratio_t cpu_ratio(input idx_t idx);
        ratio_t r;
        case (idx)
            5'd1: r = 7'd2;
            5'd2: r = 7'd4;
            default: r = 7'd1;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/clkdiv_core.sv
module clkdiv_core
    import clkdiv_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   strobe,
    input  logic   restart,
    input  ratio_t ratio,
    output logic   level,
    output logic   term
);

    ratio_t cnt_q;
    logic   level_q;
    logic   at_last;

    assign at_last = (cnt_q == ratio - ratio_t'(1));
    // terminal count: the strobe that closes the high phase
    assign term  = strobe && at_last && level_q;
    assign level = level_q;

    always_ff @(posedge clk) begin
        if (rst || restart) begin
            cnt_q   <= '0;
            level_q <= 1'b0;
        end else if (strobe) begin
            if (at_last) begin
                cnt_q   <= '0;
                level_q <= ~level_q;
            end else begin
                cnt_q <= cnt_q + ratio_t'(1);
            end
        end
    end

    // R3
    level_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!strobe && !restart) |=> $stable(level_q));

    // R3
    cnt_range_chk: assert property (@(posedge clk) disable iff (rst)
        (ratio != '0) |-> (cnt_q < ratio));

endmodule

// File: rtl/clkdiv_channel.sv
module clkdiv_channel
    import clkdiv_pkg::*;
#(
    parameter table_e TABLE = TBL_GENERAL
)(
    input  logic             clk,
    input  logic             rst,
    input  logic [N_SRC-1:0] src_edge,
    input  logic [SRC_W-1:0] sel,
    input  idx_t             idx,
    input  logic             en,
    output logic             clk_o
);

    chan_cfg_t nxt_cfg;
    chan_cfg_t cfg_q;
    logic      active_q;
    logic      strobe;
    logic      term;
    logic      level;
    logic      reload;

    // ratio decode from the selected lookup
    generate
        if (TABLE == TBL_CPU) begin : g_cpu_tbl
            always_comb begin
                nxt_cfg.src   = src_e'(sel);
                nxt_cfg.ratio = cpu_ratio(idx);
            end
        end else begin : g_gen_tbl
            always_comb begin
                nxt_cfg.src = src_e'(sel);
                case (src_e'(sel))
                    SRC_SYS:          nxt_cfg.ratio = sys_ratio(idx);
                    SRC_REF, SRC_UTL: nxt_cfg.ratio = pow2_ratio(idx);
                    default:          nxt_cfg.ratio = ratio_t'(1);
                endcase
            end
        end
    endgenerate

    // strobe follows the latched source, never the pending one
    always_comb begin
        case (cfg_q.src)
            SRC_REF: strobe = src_edge[EDGE_REF];
            SRC_SYS: strobe = src_edge[EDGE_SYS];
            SRC_UTL: strobe = src_edge[EDGE_UTL];
            default: strobe = 1'b0;
        endcase
    end

    assign reload = rst || !active_q || term;

    always_ff @(posedge clk) begin
        if (reload) begin
            cfg_q    <= nxt_cfg;
            active_q <= en && (nxt_cfg.src != SRC_OFF);
        end
    end

    clkdiv_core u_core (
        .clk     (clk),
        .rst     (rst),
        .strobe  (strobe),
        .restart (!active_q),
        .ratio   (cfg_q.ratio),
        .level   (level),
        .term    (term)
    );

    assign clk_o = level;

    // R9
    cfg_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (active_q && !term) |=> $stable(cfg_q));

    // R10
    idle_low_chk: assert property (@(posedge clk) disable iff (rst)
        !active_q |=> !clk_o);

    // R11
    parked_idle_chk: assert property (@(posedge clk) disable iff (rst)
        (cfg_q.src == SRC_OFF) |-> !active_q);

    generate
        if (TABLE == TBL_CPU) begin : g_cpu_chk
            // R6
            cpu_ratio_chk: assert property (@(posedge clk) disable iff (rst)
                (cfg_q.ratio == 7'd1) || (cfg_q.ratio == 7'd2) || (cfg_q.ratio == 7'd4));
        end else begin : g_gen_chk
            // R2
            ratio_nonzero_chk: assert property (@(posedge clk) disable iff (rst)
                cfg_q.ratio != '0);
        end
    endgenerate

endmodule

// File: rtl/clkout_divsel.sv
module clkout_divsel
    import clkdiv_pkg::*;
#(
    parameter int N_OUT = 4
)(
    input  logic                   clk,
    input  logic                   rst,
    input  logic [3:0]             src_edge,
    input  logic [SRC_W*N_OUT-1:0] out_src,
    input  logic [IDX_W*N_OUT-1:0] out_idx,
    input  logic [N_OUT-1:0]       out_en,
    input  logic [1:0]             cpu_sel,
    input  logic                   cpu_en,
    output logic [N_OUT-1:0]       clk_out,
    output logic                   cpu_clk,
    output logic                   ref_buf
);

    localparam int EDGE_CPU = 3;

    logic [N_SRC-1:0] gen_edges;
    logic [N_SRC-1:0] cpu_edges;
    logic             ref_q;

    assign gen_edges = src_edge[N_SRC-1:0];

    // processor source rides in the system slot of its own channel
    always_comb begin
        cpu_edges           = '0;
        cpu_edges[EDGE_SYS] = src_edge[EDGE_CPU];
    end

    generate
        for (genvar i = 0; i < N_OUT; i++) begin : g_out
            clkdiv_channel #(.TABLE(TBL_GENERAL)) u_chan (
                .clk      (clk),
                .rst      (rst),
                .src_edge (gen_edges),
                .sel      (out_src[i*SRC_W +: SRC_W]),
                .idx      (out_idx[i*IDX_W +: IDX_W]),
                .en       (out_en[i]),
                .clk_o    (clk_out[i])
            );
        end
    endgenerate

    clkdiv_channel #(.TABLE(TBL_CPU)) u_cpu (
        .clk      (clk),
        .rst      (rst),
        .src_edge (cpu_edges),
        .sel      (SRC_SYS),
        .idx      ({{(IDX_W-2){1'b0}}, cpu_sel}),
        .en       (cpu_en),
        .clk_o    (cpu_clk)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            ref_q <= 1'b0;
        end else if (src_edge[EDGE_REF]) begin
            ref_q <= ~ref_q;
        end
    end

    assign ref_buf = ref_q;

    // R7
    ref_buf_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !src_edge[EDGE_REF] |=> $stable(ref_buf));

    // R7
    ref_buf_flip_chk: assert property (@(posedge clk) disable iff (rst)
        src_edge[EDGE_REF] |=> (ref_buf != $past(ref_buf)));

endmodule

// File: tb/clkout_divsel_tb.sv
module clkout_divsel_tb;

    localparam int REF_SP = 3;
    localparam int SYS_SP = 1;
    localparam int UTL_SP = 2;
    localparam int CPU_SP = 1;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [3:0]  src_edge = '0;
    logic [7:0]  out_src = '0;
    logic [19:0] out_idx = '0;
    logic [3:0]  out_en = '0;
    logic [1:0]  cpu_sel = '0;
    logic        cpu_en = 1'b0;
    logic [3:0]  clk_out;
    logic        cpu_clk;
    logic        ref_buf;

    int checks = 0;
    int errors = 0;
    int c_ref = 0;
    int c_utl = 0;

    always #4 clk = ~clk;

    clkout_divsel u_dut (
        .clk      (clk),
        .rst      (rst),
        .src_edge (src_edge),
        .out_src  (out_src),
        .out_idx  (out_idx),
        .out_en   (out_en),
        .cpu_sel  (cpu_sel),
        .cpu_en   (cpu_en),
        .clk_out  (clk_out),
        .cpu_clk  (cpu_clk),
        .ref_buf  (ref_buf)
    );

    // source strobes, driven away from the active edge
    always @(negedge clk) begin
        src_edge[0] <= (c_ref == 0);
        src_edge[1] <= 1'b1;
        src_edge[2] <= (c_utl == 0);
        src_edge[3] <= 1'b1;
        c_ref <= (c_ref + 1) % REF_SP;
        c_utl <= (c_utl + 1) % UTL_SP;
    end

    function automatic logic pick(input int w);
        case (w)
            0, 1, 2, 3: return clk_out[w];
            4: return cpu_clk;
            default: return ref_buf;
        endcase
    endfunction

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic set_ch(input int ch, input int src, input int idx, input bit en);
        @(negedge clk);
        out_src[ch*2 +: 2] = src[1:0];
        out_idx[ch*5 +: 5] = idx[4:0];
        out_en[ch] = en;
    endtask

    task automatic wait_rise(input int w);
        logic prev;
        prev = pick(w);
        for (int k = 0; k < 4000; k++) begin
            @(negedge clk);
            if (!prev && pick(w)) return;
            prev = pick(w);
        end
    endtask

    // skips one full period so the measured one uses the new setting
    task automatic measure(input int w, output int hi, output int lo);
        wait_rise(w);
        wait_rise(w);
        hi = 1;
        lo = 0;
        for (int k = 0; k < 4000; k++) begin
            @(negedge clk);
            if (!pick(w)) break;
            hi++;
        end
        for (int k = 0; k < 4000; k++) begin
            if (pick(w)) break;
            lo++;
            @(negedge clk);
        end
    endtask

    task automatic expect_div(input int w, input int n, input string tag);
        int hi;
        int lo;
        measure(w, hi, lo);
        chk(hi == n, {tag, " high"}, hi, n);
        chk(lo == n, {tag, " low"}, lo, n);
    endtask

    task automatic t_reset;
        rst = 1'b1;
        repeat (3) @(negedge clk);
        chk(clk_out == 4'b0, "R1 clk_out in reset", int'(clk_out), 0);
        chk(cpu_clk == 1'b0, "R1 cpu_clk in reset", int'(cpu_clk), 0);
        chk(ref_buf == 1'b0, "R1 ref_buf in reset", int'(ref_buf), 0);
    endtask

    task automatic t_sys_table;
        int idx_l[6] = '{0, 2, 4, 5, 9, 17};
        int exp_l[6] = '{1, 3, 5, 6, 13, 104};
        foreach (idx_l[k]) begin
            set_ch(0, 1, idx_l[k], 1'b1);
            expect_div(0, exp_l[k] * SYS_SP, $sformatf("R2 R3 sys idx %0d", idx_l[k]));
        end
    endtask

    task automatic t_pow2;
        for (int k = 0; k < 4; k++) begin
            set_ch(1, 2, k, 1'b1);
            expect_div(1, (1 << k) * UTL_SP, $sformatf("R4 utl idx %0d", k));
        end
        set_ch(2, 0, 3, 1'b1);
        expect_div(2, 8 * REF_SP, "R4 ref idx 3");
    endtask

    task automatic t_unused;
        set_ch(0, 1, 20, 1'b1);
        expect_div(0, SYS_SP, "R5 sys idx 20");
        set_ch(1, 2, 9, 1'b1);
        expect_div(1, UTL_SP, "R5 utl idx 9");
    endtask

    task automatic t_cpu;
        int exp_l[4] = '{1, 2, 4, 1};
        cpu_en = 1'b1;
        for (int k = 0; k < 4; k++) begin
            @(negedge clk);
            cpu_sel = k[1:0];
            expect_div(4, exp_l[k] * CPU_SP, $sformatf("R6 cpu sel %0d", k));
        end
    endtask

    task automatic t_refbuf;
        expect_div(5, REF_SP, "R7 ref_buf");
    endtask

    task automatic t_align;
        int bad_eq = 0;
        int bad_rel = 0;
        logic p0;
        logic p2;
        set_ch(0, 1, 4, 1'b1);
        set_ch(1, 1, 4, 1'b1);
        set_ch(3, 1, 4, 1'b1);
        set_ch(2, 1, 7, 1'b1);
        rst = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        p0 = clk_out[0];
        p2 = clk_out[2];
        for (int k = 0; k < 300; k++) begin
            @(negedge clk);
            if (clk_out[0] != clk_out[1] || clk_out[0] != clk_out[3]) bad_eq++;
            if ((clk_out[2] != p2) && (clk_out[0] == p0)) bad_rel++;
            p0 = clk_out[0];
            p2 = clk_out[2];
        end
        chk(bad_eq == 0, "R8 same ratio in phase", bad_eq, 0);
        chk(bad_rel == 0, "R8 related ratio edges", bad_rel, 0);
    endtask

    task automatic t_glitchless;
        int hi = 0;
        int lo = 0;
        set_ch(0, 1, 10, 1'b1);
        expect_div(0, 20, "R9 settle /20");
        wait_rise(0);
        hi = 1;
        for (int k = 0; k < 200; k++) begin
            if (hi == 5) out_idx[4:0] = 5'd2;
            @(negedge clk);
            if (!clk_out[0]) break;
            hi++;
        end
        for (int k = 0; k < 200; k++) begin
            if (clk_out[0]) break;
            lo++;
            @(negedge clk);
        end
        chk(hi == 20, "R9 high phase keeps old length", hi, 20);
        chk(lo == 3, "R9 next low phase uses new ratio", lo, 3);
    endtask

    task automatic t_disable;
        int highs = 0;
        set_ch(1, 1, 4, 1'b0);
        repeat (40) @(negedge clk);
        for (int k = 0; k < 100; k++) begin
            @(negedge clk);
            if (clk_out[1]) highs++;
        end
        chk(highs == 0, "R10 disabled output low", highs, 0);
        set_ch(1, 1, 4, 1'b1);
        expect_div(1, 5, "R10 re-enabled output");
        highs = 0;
        set_ch(3, 3, 0, 1'b1);
        repeat (40) @(negedge clk);
        for (int k = 0; k < 100; k++) begin
            @(negedge clk);
            if (clk_out[3]) highs++;
        end
        chk(highs == 0, "R11 parked source low", highs, 0);
    endtask

    initial begin
        #(8 * 150000);
        errors++;
        $display("FAIL watchdog actual=hung expected=complete");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        out_src = 8'b01_01_01_01;
        out_idx = '0;
        out_en  = 4'hF;
        cpu_en  = 1'b1;
        t_reset;
        @(negedge clk);
        rst = 1'b0;
        t_sys_table;
        t_pow2;
        t_unused;
        t_cpu;
        t_refbuf;
        t_align;
        t_glitchless;
        t_disable;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule